// File: doc/BRIEF.md
# Multi Resolution Real Time Counter

This block keeps a 53-bit free-running time count whose least significant bit weighs 250 ns. The bit positions run from 50 down to -2. A clock-enable pulse arrives from the low-frequency clock domain, and on each pulse the count advances by a programmable step given in 250 ns units. For a 32.768 kHz tick that step is 122. The count wraps modulo 2^53.

Software acts on the count through two write strobes:
- A clear strobe that restarts the count from zero.
- A delta-adjust write that adds a signed correction. Bit 31 of the written word is an exponent and bits 30:0 are a two's-complement mantissa. The exponent selects a unit of either 250 ns or 2^22 × 250 ns (about 1.049 s).

A freeze-mode input decides whether a core-halted input stops the count while it is asserted. The block presents the full count and four overlapping 32-bit windows at 250 ns, 1 µs, 8 µs and about 0.5 s resolution.

Top module: `rtcount_top`

## Requirements
- R1: After synchronous reset the full count and all four windows read zero. Bit i of `count_o` has weight 2^(i-2) µs.
- R2: The windows are slices of the count by time position: `win_q250_o` = positions [29:-2], `win_1us_o` = [31:0], `win_8us_o` = [34:3], `win_half_o` = [50:19]. Position p is bit p+2 of `count_o`.
- R3: A clear strobe with data bit 1 sets the count to zero at the next edge, and counting resumes from zero. A clear strobe with data bit 0 has no effect on the count.
- R4: A cycle with `tick_i` high and no freeze adds `step_i` to the count at the next edge.
- R5: Every addition wraps modulo 2^53.
- R6: A delta write with bit 31 = 0 adds the sign-extended bits [30:0] in 250 ns units.
- R7: A delta write with bit 31 = 1 adds the sign-extended bits [30:0] multiplied by 2^22.
- R8: With `frz_mode_i` = 1, ticks are ignored while `core_halt_i` is high. Counting resumes once it drops. Clear and delta writes still act during the freeze.
- R9: With `frz_mode_i` = 0, `core_halt_i` has no effect on counting.
- R10: A tick and a delta write in the same cycle are both applied at that edge. A clear in the same cycle overrides both.
- R11: With no tick, no clear and no delta write, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle advance enable from the slow clock domain |
| step_i | input | STEP_W | Increment per tick, 250 ns units |
| clr_wr_i | input | 1 | Clear register write strobe |
| clr_data_i | input | 1 | Clear register write data (1 clears) |
| dlt_wr_i | input | 1 | Delta-adjust write strobe |
| dlt_data_i | input | 32 | Delta word: [31] exponent, [30:0] signed mantissa |
| frz_mode_i | input | 1 | 1 = honour core halt, 0 = ignore it |
| core_halt_i | input | 1 | Core halted indication |
| count_o | output | 53 | Full count, positions [50:-2] |
| win_q250_o | output | 32 | Window at 250 ns resolution |
| win_1us_o | output | 32 | Window at 1 µs resolution |
| win_8us_o | output | 32 | Window at 8 µs resolution |
| win_half_o | output | 32 | Window at about 0.5 s resolution |

## Verification
The hardest behaviour to reach from the ports is the wrap at 2^53. Ticks alone would take years of simulated time to carry into the top bits. The stimulus therefore first issues an exponent-1 delta of -1, which lands the count at 2^53 - 2^22. A 250 ns-unit delta then places it three steps below the top, and a tick of five carries it across to 2. The same delta path loads a scattered bit pattern so that each window's slice boundary can be compared against the full count.

// File: rtl/rtcount_pkg.sv
package rtcount_pkg;

    localparam int CNT_W     = 53;   // positions [50:-2]
    localparam int POS_OFF   = 2;    // bit index = position + POS_OFF
    localparam int WIN_W     = 32;
    localparam int WIN_N     = 4;
    localparam int DLT_W     = 32;
    localparam int MANT_W    = DLT_W - 1;
    localparam int EXP_SHIFT = 22;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [WIN_W-1:0] win_t;

    typedef enum logic [1:0] {
        WIN_Q250 = 2'd0,
        WIN_1US  = 2'd1,
        WIN_8US  = 2'd2,
        WIN_HALF = 2'd3
    } win_sel_e;

    // per-cycle update request assembled from the edge inputs
    typedef struct packed {
        logic clear;
        logic advance;
        logic adjust;
    } upd_t;

    // lowest time position carried by each window
    function automatic int win_lsb_pos(input int idx);
        case (idx)
            0:       return -2;
            1:       return 0;
            2:       return 3;
            default: return 19;
        endcase
    endfunction

    // sign-extend mantissa and apply exponent scale
    function automatic cnt_t delta_addend(input logic [DLT_W-1:0] w);
        cnt_t ext;
        ext = {{(CNT_W-MANT_W){w[MANT_W-1]}}, w[MANT_W-1:0]};
        return w[DLT_W-1] ? (ext << EXP_SHIFT) : ext;
    endfunction

endpackage

// File: rtl/rtcount_gate.sv
module rtcount_gate
    import rtcount_pkg::*;
#(
    parameter int STEP_W = 12
) (
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              frz_mode_i,
    input  logic              core_halt_i,
    output logic              advance_o,
    output cnt_t              inc_o
);
    logic frozen;

    assign frozen    = frz_mode_i & core_halt_i;
    assign advance_o = tick_i & ~frozen;
    assign inc_o     = advance_o ? cnt_t'(step_i) : '0;

endmodule

// File: rtl/rtcount_delta.sv
module rtcount_delta
    import rtcount_pkg::*;
(
    input  logic             wr_i,
    input  logic [DLT_W-1:0] data_i,
    output cnt_t             addend_o
);
    assign addend_o = wr_i ? delta_addend(data_i) : '0;
endmodule

// File: rtl/rtcount_views.sv
module rtcount_views
    import rtcount_pkg::*;
(
    input  cnt_t count_i,
    output win_t win_o [WIN_N]
);
    for (genvar g = 0; g < WIN_N; g++) begin : g_win
        localparam int LO = win_lsb_pos(g) + POS_OFF;
        assign win_o[g] = count_i[LO +: WIN_W];
    end
endmodule

// File: rtl/rtcount_top.sv
module rtcount_top
    import rtcount_pkg::*;
#(
    parameter int STEP_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              clr_wr_i,
    input  logic              clr_data_i,
    input  logic              dlt_wr_i,
    input  logic [31:0]       dlt_data_i,
    input  logic              frz_mode_i,
    input  logic              core_halt_i,
    output logic [52:0]       count_o,
    output logic [31:0]       win_q250_o,
    output logic [31:0]       win_1us_o,
    output logic [31:0]       win_8us_o,
    output logic [31:0]       win_half_o
);
    cnt_t count_q;
    cnt_t count_d;
    cnt_t tick_inc;
    cnt_t adj_inc;
    upd_t upd;
    win_t wins [WIN_N];

    rtcount_gate #(.STEP_W(STEP_W)) u_gate (
        .tick_i      (tick_i),
        .step_i      (step_i),
        .frz_mode_i  (frz_mode_i),
        .core_halt_i (core_halt_i),
        .advance_o   (upd.advance),
        .inc_o       (tick_inc)
    );

    rtcount_delta u_delta (
        .wr_i     (dlt_wr_i),
        .data_i   (dlt_data_i),
        .addend_o (adj_inc)
    );

    assign upd.clear  = clr_wr_i & clr_data_i;
    assign upd.adjust = dlt_wr_i;

    // clear wins; tick and delta combine in one add
    always_comb begin
        if (upd.clear)
            count_d = '0;
        else if (upd.advance || upd.adjust)
            count_d = count_q + tick_inc + adj_inc;
        else
            count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    rtcount_views u_views (
        .count_i (count_q),
        .win_o   (wins)
    );

    assign count_o    = count_q;
    assign win_q250_o = wins[WIN_Q250];
    assign win_1us_o  = wins[WIN_1US];
    assign win_8us_o  = wins[WIN_8US];
    assign win_half_o = wins[WIN_HALF];

endmodule

// File: rtl/rtcount_chk.sv
module rtcount_chk #(
    parameter int STEP_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic [STEP_W-1:0] step_i,
    input logic              clr_wr_i,
    input logic              clr_data_i,
    input logic              dlt_wr_i,
    input logic              frz_mode_i,
    input logic              core_halt_i,
    input logic [52:0]       count_o,
    input logic [31:0]       win_q250_o,
    input logic [31:0]       win_1us_o,
    input logic [31:0]       win_8us_o,
    input logic [31:0]       win_half_o
);
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> count_o == '0);

    a_r2_win_align: assert property (@(posedge clk) disable iff (rst)
        (win_1us_o[29:0] == win_q250_o[31:2]) && (win_8us_o[28:0] == win_1us_o[31:3])
        && (win_half_o == count_o[52:21]));

    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr_i && clr_data_i) |=> count_o == '0);

    a_r4_tick_add: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !(frz_mode_i && core_halt_i) && !clr_wr_i && !dlt_wr_i)
        |=> count_o == $past(count_o) + 53'($past(step_i)));

    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (frz_mode_i && core_halt_i && !clr_wr_i && !dlt_wr_i) |=> $stable(count_o));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_wr_i && !dlt_wr_i) |=> $stable(count_o));
endmodule

bind rtcount_top rtcount_chk #(.STEP_W(STEP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .step_i      (step_i),
    .clr_wr_i    (clr_wr_i),
    .clr_data_i  (clr_data_i),
    .dlt_wr_i    (dlt_wr_i),
    .frz_mode_i  (frz_mode_i),
    .core_halt_i (core_halt_i),
    .count_o     (count_o),
    .win_q250_o  (win_q250_o),
    .win_1us_o   (win_1us_o),
    .win_8us_o   (win_8us_o),
    .win_half_o  (win_half_o)
);

// File: tb/tb_rtcount_top.sv
module tb_rtcount_top;
    localparam int STEP_W = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick_i;
    logic [STEP_W-1:0] step_i;
    logic              clr_wr_i;
    logic              clr_data_i;
    logic              dlt_wr_i;
    logic [31:0]       dlt_data_i;
    logic              frz_mode_i;
    logic              core_halt_i;
    logic [52:0]       count_o;
    logic [31:0]       win_q250_o, win_1us_o, win_8us_o, win_half_o;

    int   n_vec = 0;
    int   n_bad = 0;
    logic [52:0] model;

    always #2 clk = ~clk;

    rtcount_top #(.STEP_W(STEP_W)) dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .step_i(step_i),
        .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .dlt_wr_i(dlt_wr_i), .dlt_data_i(dlt_data_i),
        .frz_mode_i(frz_mode_i), .core_halt_i(core_halt_i),
        .count_o(count_o), .win_q250_o(win_q250_o), .win_1us_o(win_1us_o),
        .win_8us_o(win_8us_o), .win_half_o(win_half_o)
    );

    function automatic logic [52:0] dlt_val(input logic [31:0] w);
        logic [52:0] m;
        m = {{22{w[30]}}, w[30:0]};
        return w[31] ? (m << 22) : m;
    endfunction

    task automatic check(input string req, input logic [52:0] act, input logic [52:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; inputs driven 1 ns after the edge
    task automatic cyc(input logic t, input logic [STEP_W-1:0] s, input logic cw,
                       input logic cd, input logic dw, input logic [31:0] dd);
        tick_i = t; step_i = s; clr_wr_i = cw; clr_data_i = cd;
        dlt_wr_i = dw; dlt_data_i = dd;
        @(posedge clk); #1;
        tick_i = 0; clr_wr_i = 0; dlt_wr_i = 0; clr_data_i = 0;
    endtask

    task automatic t_reset;
        check("R1 count", count_o, 53'd0);
        check("R1 win_half", {21'd0, win_half_o}, 53'd0);
    endtask

    task automatic t_ticks;
        cyc(1, 12'd122, 0, 0, 0, 0); model = 53'd122;
        check("R4 first tick", count_o, model);
        for (int i = 0; i < 5; i++) begin
            cyc(1, 12'd122, 0, 0, 0, 0); model += 53'd122;
        end
        check("R4 six ticks", count_o, model);
        cyc(1, 12'hFFF, 0, 0, 0, 0); model += 53'hFFF;
        check("R4 max step", count_o, model);
        cyc(0, 12'd7, 0, 0, 0, 0);
        check("R11 idle hold", count_o, model);
    endtask

    task automatic t_clear;
        cyc(0, 0, 1, 0, 0, 0);
        check("R3 write 0 no effect", count_o, model);
        cyc(0, 0, 1, 1, 0, 0); model = 0;
        check("R3 clear", count_o, model);
        cyc(1, 12'd9, 0, 0, 0, 0); model = 53'd9;
        check("R3 resume from zero", count_o, model);
    endtask

    task automatic t_delta;
        cyc(0, 0, 0, 0, 1, 32'h0000_1000); model += 53'h1000;
        check("R6 positive E0", count_o, model);
        cyc(0, 0, 0, 0, 1, 32'h7FFF_FFF0); model -= 53'd16;
        check("R6 negative E0", count_o, model);
        cyc(0, 0, 0, 0, 1, 32'h8000_0003); model += (53'd3 << 22);
        check("R7 positive E1", count_o, model);
        cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF); model -= (53'd1 << 22);
        check("R7 negative E1", count_o, model);
        check("R7 independent formula", model, 53'd9 + 53'h1000 - 53'd16 + (53'd2 << 22));
    endtask

    task automatic t_windows;
        cyc(0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 32'h8012_3457); model = dlt_val(32'h8012_3457);
        cyc(0, 0, 0, 0, 1, 32'h01AB_CDEF); model += dlt_val(32'h01AB_CDEF);
        check("R2 count", count_o, model);
        check("R2 win 250ns", {21'd0, win_q250_o}, {21'd0, model[31:0]});
        check("R2 win 1us",   {21'd0, win_1us_o},  {21'd0, model[33:2]});
        check("R2 win 8us",   {21'd0, win_8us_o},  {21'd0, model[36:5]});
        check("R2 win half",  {21'd0, win_half_o}, {21'd0, model[52:21]});
    endtask

    task automatic t_wrap;
        cyc(0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        check("R5 near top", count_o, 53'h1F_FFFF_FFC0_0000);
        cyc(0, 0, 0, 0, 1, 32'h003F_FFFD);
        check("R5 top minus 3", count_o, {53{1'b1}} - 53'd2);
        cyc(1, 12'd5, 0, 0, 0, 0);
        check("R5 wrap", count_o, 53'd2);
        model = 53'd2;
    endtask

    task automatic t_freeze;
        frz_mode_i = 1; core_halt_i = 1;
        cyc(1, 12'd50, 0, 0, 0, 0);
        check("R8 frozen tick", count_o, model);
        cyc(0, 0, 0, 0, 1, 32'h0000_0010); model += 53'd16;
        check("R8 delta during freeze", count_o, model);
        core_halt_i = 0;
        cyc(1, 12'd50, 0, 0, 0, 0); model += 53'd50;
        check("R8 resume", count_o, model);
        frz_mode_i = 0; core_halt_i = 1;
        cyc(1, 12'd50, 0, 0, 0, 0); model += 53'd50;
        check("R9 halt ignored", count_o, model);
        core_halt_i = 0;
    endtask

    task automatic t_combined;
        cyc(1, 12'd100, 0, 0, 1, 32'h8000_0001); model += 53'd100 + (53'd1 << 22);
        check("R10 tick plus delta", count_o, model);
        cyc(1, 12'd100, 1, 1, 1, 32'h0000_0055); model = 0;
        check("R10 clear priority", count_o, model);
    endtask

    initial begin : watchdog
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1; tick_i = 0; step_i = 0; clr_wr_i = 0; clr_data_i = 0;
        dlt_wr_i = 0; dlt_data_i = 0; frz_mode_i = 0; core_halt_i = 0;
        model = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_ticks();
        t_clear();
        t_delta();
        t_windows();
        t_wrap();
        t_freeze();
        t_combined();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule